// File: doc/BRIEF.md
# Cascadable ALU Slice

This block is a sixteen-bit arithmetic and logic slice. It is meant to be placed side by side with copies of itself to build a wider datapath. Each operand port has its own holding register. A two-bit routing code chooses what reaches the two ALU inputs, called R and S. The choices are the operands, zero, or the slice's own stored result, so the slice can keep a running total. A three-bit operation code then picks one of eight operations. The result passes through an output register to the output port.

Each register stage can be switched to transparent operation. This gives a result latency of zero, one or two clock cycles. The slice reports carry out, signed overflow and zero. It also reports group propagate and generate, for use by an external lookahead carry unit.

To chain slices, the carry out of each slice feeds the carry in of the next. All control lines are shared between the slices. The most significant slice supplies the word's carry, overflow and lookahead flags, and the word's zero flag is the AND of the slice zero flags.

Top module: `alu_slice`

## Requirements
- R1: A synchronous active-high reset clears the A, B and result registers to zero.
- R2: Each register (A, B, result) loads at a clock edge only while its own load input is low. While that input is high, the register keeps its value.
- R3: When `pass_ab` is high, the A and B registers are bypassed. When `pass_f` is high, the result register is bypassed at the output. The result therefore appears 2, 1, 1 or 0 clock edges after the operands for (pass_ab, pass_f) = (0,0), (1,0), (0,1) and (1,1).
- R4: The routing code `sel` sets the ALU inputs R and S:
  - 0 gives R=A and S=stored result.
  - 1 gives R=A and S=0.
  - 2 gives R=0 and S=B.
  - 3 gives R=A and S=B.
- R5: Operation codes 0 and 7 force the result to all zeros and all ones. Codes 4, 5 and 6 give R XOR S, R OR S and R AND S.
- R6: Operation code 1 gives S + ~R + cin. Code 2 gives R + ~S + cin. Code 3 gives R + S + cin. All three are modulo 2^16.
- R7: For codes 1 to 3, `cout` is the carry out of bit 15 and `ovf` flags signed (two's complement) overflow. For every other code, both are 0.
- R8: `zero` is high exactly when the ALU result is all zeros.
- R9: The adder inputs are X and Y (R and S after any inversion; R and S for non-arithmetic codes). `grp_p` is the AND over all bits of (X OR Y). `grp_g` is the carry out of X + Y with no carry in. For arithmetic codes, `cout` equals `grp_g | (grp_p & cin)`.
- R10: While `out_en_n` is high, `f_out` is all zeros and `f_valid` is low. While it is low, `f_out` carries the selected result and `f_valid` is high.
- R11: The value routed back to S always comes from the result register, whatever `pass_f` is. Repeated loads with code 3 and `sel`=0 therefore accumulate A.
- R12: Two slices whose carry out and carry in are joined produce the 32-bit result, with carry and overflow taken from the upper slice and zero taken as the AND of both zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| a_load_n | input | 1 | Load for A register, active low |
| b_load_n | input | 1 | Load for B register, active low |
| f_load_n | input | 1 | Load for result register, active low |
| pass_ab | input | 1 | Bypass the A and B registers |
| pass_f | input | 1 | Bypass the result register at the output |
| sel | input | 2 | Routing code for R and S |
| fn | input | 3 | Operation code |
| cin | input | 1 | Carry in |
| out_en_n | input | 1 | Output enable, active low |
| f_out | output | 16 | Result port |
| f_valid | output | 1 | High while the result port is driven |
| cout | output | 1 | Carry out |
| ovf | output | 1 | Signed overflow |
| zero | output | 1 | ALU result is zero |
| grp_p | output | 1 | Group propagate |
| grp_g | output | 1 | Group generate |

## Verification
The hold assertion assumes that `pass_f` and `out_en_n` stay constant across the edge being checked. The bench only changes them during set-up phases, and the assertion requires them to be equal on both sides. The zero and adder-identity assertions apply only when both stages are transparent, because only then does the port show the ALU result in the same cycle. The bench reaches that state in one quarter of its sweep. The stored result is preloaded through routing code 1 with the input stage transparent, so that feedback vectors start from a value the bench knows.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef enum logic [2:0] {
    FN_CLEAR = 3'd0,
    FN_S_MINUS_R = 3'd1,
    FN_R_MINUS_S = 3'd2,
    FN_ADD = 3'd3,
    FN_XOR = 3'd4,
    FN_OR = 3'd5,
    FN_AND = 3'd6,
    FN_SET = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    SEL_A_FB = 2'd0,
    SEL_A_ZERO = 2'd1,
    SEL_ZERO_B = 2'd2,
    SEL_A_B = 2'd3
  } alu_sel_e;

  function automatic logic fn_is_arith(input alu_fn_e f);
    return (f == FN_S_MINUS_R) || (f == FN_R_MINUS_S) || (f == FN_ADD);
  endfunction

endpackage

// File: rtl/operand_reg.sv
module operand_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             bypass,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (!load_n) held <= d;
  end

  assign q = bypass ? d : held;
endmodule

// File: rtl/operand_mux.sv
module operand_mux
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_sel_e         sel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [WIDTH-1:0] fb,
  output logic [WIDTH-1:0] r,
  output logic [WIDTH-1:0] s
);
  always_comb begin
    unique case (sel)
      SEL_A_FB:   begin r = a;  s = fb; end
      SEL_A_ZERO: begin r = a;  s = '0; end
      SEL_ZERO_B: begin r = '0; s = b;  end
      default:    begin r = a;  s = b;  end
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  alu_fn_e          fn,
  input  logic [WIDTH-1:0] r,
  input  logic [WIDTH-1:0] s,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout,
  output logic             ovf,
  output logic             zero,
  output logic             grp_p,
  output logic             grp_g
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x_op, y_op, bit_p, bit_g, sum;
  logic [WIDTH:0]   carry;   // chain seeded by cin
  logic [WIDTH:0]   gchain;  // chain seeded by zero, for group generate
  logic             arith;

  always_comb begin
    unique case (fn)
      FN_S_MINUS_R: begin x_op = ~r; y_op = s;  end
      FN_R_MINUS_S: begin x_op = r;  y_op = ~s; end
      default:      begin x_op = r;  y_op = s;  end
    endcase
  end

  assign bit_p = x_op | y_op;
  assign bit_g = x_op & y_op;
  assign carry[0] = cin;
  assign gchain[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign carry[i+1]  = bit_g[i] | (bit_p[i] & carry[i]);
    assign gchain[i+1] = bit_g[i] | (bit_p[i] & gchain[i]);
    assign sum[i]      = x_op[i] ^ y_op[i] ^ carry[i];
  end

  assign arith = fn_is_arith(fn);

  always_comb begin
    unique case (fn)
      FN_CLEAR: y = '0;
      FN_XOR:   y = r ^ s;
      FN_OR:    y = r | s;
      FN_AND:   y = r & s;
      FN_SET:   y = '1;
      default:  y = sum;
    endcase
  end

  assign cout  = arith & carry[WIDTH];
  assign ovf   = arith & (carry[WIDTH] ^ carry[MSB]);
  assign zero  = (y == '0);
  assign grp_p = &bit_p;
  assign grp_g = gchain[WIDTH];
endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             bypass,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else if (!load_n) held <= d;
  end

  assign q = bypass ? d : held;
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             a_load_n,
  input  logic             b_load_n,
  input  logic             f_load_n,
  input  logic             pass_ab,
  input  logic             pass_f,
  input  logic [1:0]       sel,
  input  logic [2:0]       fn,
  input  logic             cin,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] f_out,
  output logic             f_valid,
  output logic             cout,
  output logic             ovf,
  output logic             zero,
  output logic             grp_p,
  output logic             grp_g
);
  logic [WIDTH-1:0] a_q, b_q, r_op, s_op, alu_y, f_held, f_q;

  operand_reg #(.WIDTH(WIDTH)) u_a_reg (
    .clk(clk), .rst(rst), .load_n(a_load_n), .bypass(pass_ab), .d(a_in), .q(a_q)
  );

  operand_reg #(.WIDTH(WIDTH)) u_b_reg (
    .clk(clk), .rst(rst), .load_n(b_load_n), .bypass(pass_ab), .d(b_in), .q(b_q)
  );

  operand_mux #(.WIDTH(WIDTH)) u_mux (
    .sel(alu_sel_e'(sel)), .a(a_q), .b(b_q), .fb(f_held), .r(r_op), .s(s_op)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .fn(alu_fn_e'(fn)), .r(r_op), .s(s_op), .cin(cin), .y(alu_y),
    .cout(cout), .ovf(ovf), .zero(zero), .grp_p(grp_p), .grp_g(grp_g)
  );

  result_stage #(.WIDTH(WIDTH)) u_f_reg (
    .clk(clk), .rst(rst), .load_n(f_load_n), .bypass(pass_f), .d(alu_y),
    .held(f_held), .q(f_q)
  );

  assign f_out   = out_en_n ? '0 : f_q;
  assign f_valid = ~out_en_n;
endmodule

// File: rtl/alu_slice_checks.sv
module alu_slice_checks #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             f_load_n,
  input logic             pass_ab,
  input logic             pass_f,
  input logic [1:0]       sel,
  input logic [2:0]       fn,
  input logic             cin,
  input logic             out_en_n,
  input logic [WIDTH-1:0] f_out,
  input logic             f_valid,
  input logic             cout,
  input logic             ovf,
  input logic             zero,
  input logic             grp_p,
  input logic             grp_g
);
  logic armed;
  logic is_arith;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else armed <= 1'b1;
  end

  assign is_arith = (fn == 3'd1) || (fn == 3'd2) || (fn == 3'd3);

  // R9: lookahead identity on the carry out
  p_lookahead_r9: assert property (@(posedge clk) disable iff (rst)
    is_arith |-> (cout == (grp_g | (grp_p & cin))));

  // R7: no carry or overflow outside arithmetic codes
  p_no_flags_r7: assert property (@(posedge clk) disable iff (rst)
    !is_arith |-> (!cout && !ovf));

  // R10: disabled port is quiet
  p_port_off_r10: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (!f_valid && f_out == '0));

  // R2: result register keeps its value while its load is high
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !pass_f && !out_en_n && $past(f_load_n) && !$past(pass_f) && !$past(out_en_n))
      |-> $stable(f_out));

  // R8: zero flag agrees with a transparent output
  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (pass_ab && pass_f && !out_en_n) |-> (zero == (f_out == '0)));

  // R6: fully transparent add matches the operand ports
  p_add_r6: assert property (@(posedge clk) disable iff (rst)
    (pass_ab && pass_f && !out_en_n && fn == 3'd3 && sel == 2'd3)
      |-> ({cout, f_out} == ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, cin})));
endmodule

bind alu_slice alu_slice_checks #(.WIDTH(WIDTH)) u_checks (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .f_load_n(f_load_n),
  .pass_ab(pass_ab), .pass_f(pass_f), .sel(sel), .fn(fn), .cin(cin),
  .out_en_n(out_en_n), .f_out(f_out), .f_valid(f_valid), .cout(cout),
  .ovf(ovf), .zero(zero), .grp_p(grp_p), .grp_g(grp_g)
);

// File: tb/alu_slice_test.sv
`timescale 1ns/1ps
module alu_slice_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] a32 = '0, b32 = '0;
  logic a_load_n = 1'b0, b_load_n = 1'b0, f_load_n = 1'b0;
  logic pass_ab = 1'b0, pass_f = 1'b0;
  logic [1:0] sel = 2'd3;
  logic [2:0] fn = 3'd3;
  logic cin_sys = 1'b0, out_en_n = 1'b0;
  logic [15:0] lo_f, hi_f;
  logic lo_v, hi_v, c_mid, hi_cout, lo_ovf, hi_ovf, lo_z, hi_z, lo_p, lo_g, hi_p, hi_g;
  int nvec = 0, nerr = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  alu_slice #(.WIDTH(16)) uut (
    .clk(clk), .rst(rst), .a_in(a32[15:0]), .b_in(b32[15:0]),
    .a_load_n(a_load_n), .b_load_n(b_load_n), .f_load_n(f_load_n),
    .pass_ab(pass_ab), .pass_f(pass_f), .sel(sel), .fn(fn), .cin(cin_sys),
    .out_en_n(out_en_n), .f_out(lo_f), .f_valid(lo_v), .cout(c_mid),
    .ovf(lo_ovf), .zero(lo_z), .grp_p(lo_p), .grp_g(lo_g)
  );

  alu_slice #(.WIDTH(16)) uut_upper (
    .clk(clk), .rst(rst), .a_in(a32[31:16]), .b_in(b32[31:16]),
    .a_load_n(a_load_n), .b_load_n(b_load_n), .f_load_n(f_load_n),
    .pass_ab(pass_ab), .pass_f(pass_f), .sel(sel), .fn(fn), .cin(c_mid),
    .out_en_n(out_en_n), .f_out(hi_f), .f_valid(hi_v), .cout(hi_cout),
    .ovf(hi_ovf), .zero(hi_z), .grp_p(hi_p), .grp_g(hi_g)
  );

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // 32-bit reference of the chained pair plus lower-slice lookahead terms
  task automatic model(input logic [1:0] sl, input logic [2:0] f, input logic ci,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] fv,
                       output logic [31:0] res, output logic co, output logic ov,
                       output logic zr, output logic plo, output logic glo);
    logic [31:0] r, s, x, y;
    logic [32:0] sum;
    logic [16:0] lo17;
    logic ar;
    case (sl)
      2'd0: begin r = a;  s = fv; end
      2'd1: begin r = a;  s = '0; end
      2'd2: begin r = '0; s = b;  end
      default: begin r = a; s = b; end
    endcase
    ar = (f == 3'd1) || (f == 3'd2) || (f == 3'd3);
    x = (f == 3'd1) ? ~r : r;
    y = (f == 3'd2) ? ~s : s;
    sum = {1'b0, x} + {1'b0, y} + {32'd0, ci};
    case (f)
      3'd0: res = '0;
      3'd4: res = r ^ s;
      3'd5: res = r | s;
      3'd6: res = r & s;
      3'd7: res = '1;
      default: res = sum[31:0];
    endcase
    co = ar & sum[32];
    ov = ar & (x[31] == y[31]) & (sum[31] != x[31]);
    zr = (res == '0);
    lo17 = {1'b0, x[15:0]} + {1'b0, y[15:0]};
    glo = lo17[16];
    plo = &(x[15:0] | y[15:0]);
  endtask

  task automatic apply(input logic [1:0] md, input logic [1:0] sl, input logic [2:0] f,
                       input logic ci, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] fv);
    logic [31:0] er;
    logic eco, eov, ezr, ep, eg;
    model(sl, f, ci, a, b, fv, er, eco, eov, ezr, ep, eg);
    // preload the result register with fv (R=A, S=0, add, no carry)
    pass_ab = 1'b1; sel = 2'd1; fn = 3'd3; cin_sys = 1'b0;
    a32 = fv; b32 = '0; a_load_n = 1'b1; b_load_n = 1'b1; f_load_n = 1'b0;
    tick();
    f_load_n = 1'b1; a_load_n = 1'b0; b_load_n = 1'b0;
    pass_ab = md[1]; pass_f = md[0]; sel = sl; fn = f; cin_sys = ci; a32 = a; b32 = b;
    tick();
    a_load_n = 1'b1; b_load_n = 1'b1;
    #1;
    chk("R7 R12 carry", {32'd0, hi_cout}, {32'd0, eco});
    chk("R7 R12 overflow", {32'd0, hi_ovf}, {32'd0, eov});
    chk("R8 R12 zero", {32'd0, lo_z & hi_z}, {32'd0, ezr});
    chk("R9 propagate", {32'd0, lo_p}, {32'd0, ep});
    chk("R9 generate", {32'd0, lo_g}, {32'd0, eg});
    if (!md[0]) begin
      f_load_n = 1'b0;
      tick();
      f_load_n = 1'b1;
      #1;
    end
    chk("R4 R5 R6 R12 result", {1'b0, hi_f, lo_f}, {1'b0, er});
  endtask

  function automatic logic [63:0] pattern(input int i);
    case (i)
      0: return {32'h0000_0000, 32'h0000_0000};
      1: return {32'hFFFF_FFFF, 32'h0000_0001};
      2: return {32'h7FFF_FFFF, 32'h0000_0001};
      3: return {32'h8000_0000, 32'h8000_0000};
      4: return {32'h1234_ABCD, 32'h0000_FFFF};
      default: return {32'h0000_FFFF, 32'h0000_FFFF};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    a32 = 32'd123; b32 = 32'd456; a_load_n = 1'b1; b_load_n = 1'b1; f_load_n = 1'b1;
    #1;
    chk("R1 result register cleared", {1'b0, hi_f, lo_f}, 33'd0);
    pass_f = 1'b1;
    #1;
    chk("R1 operand registers cleared", {1'b0, hi_f, lo_f}, 33'd0);
    chk("R1 R8 zero after reset", {32'd0, lo_z & hi_z}, 33'd1);

    // R10: output enable
    out_en_n = 1'b1;
    a32 = 32'd5;
    pass_ab = 1'b1;
    #1;
    chk("R10 port off data", {1'b0, hi_f, lo_f}, 33'd0);
    chk("R10 port off valid", {31'd0, hi_v, lo_v}, 33'd0);
    out_en_n = 1'b0;
    #1;
    chk("R10 port on data", {1'b0, hi_f, lo_f}, {1'b0, 32'd461});
    chk("R10 port on valid", {31'd0, hi_v, lo_v}, 33'd3);

    // R2: load enables
    @(negedge clk);
    pass_ab = 1'b0; pass_f = 1'b1; sel = 2'd3; fn = 3'd3; cin_sys = 1'b0;
    a32 = 32'd7; b32 = 32'd3; a_load_n = 1'b0; b_load_n = 1'b0; f_load_n = 1'b1;
    tick();
    a_load_n = 1'b1; b_load_n = 1'b1; a32 = 32'd99; b32 = 32'd99;
    tick(); #1;
    chk("R2 operand hold", {1'b0, hi_f, lo_f}, 33'd10);
    pass_f = 1'b0; f_load_n = 1'b0;
    tick();
    f_load_n = 1'b1; a_load_n = 1'b0; a32 = 32'd50;
    tick(); #1;
    chk("R2 result hold", {1'b0, hi_f, lo_f}, 33'd10);
    a_load_n = 1'b1; f_load_n = 1'b0;
    tick(); #1;
    chk("R2 result load", {1'b0, hi_f, lo_f}, 33'd53);
    f_load_n = 1'b1;

    // R3: latency per flow-through mode
    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      pass_ab = m[1]; pass_f = m[0]; sel = 2'd3; fn = 3'd3; cin_sys = 1'b0;
      a_load_n = 1'b0; b_load_n = 1'b0; f_load_n = 1'b0; a32 = '0; b32 = '0;
      repeat (3) tick();
      a32 = 32'd100; b32 = 32'd23;
      #1;
      chk("R3 latency edge 0", {1'b0, hi_f, lo_f}, (m == 3) ? 33'd123 : 33'd0);
      tick(); #1;
      chk("R3 latency edge 1", {1'b0, hi_f, lo_f}, (m != 0) ? 33'd123 : 33'd0);
      tick(); #1;
      chk("R3 latency edge 2", {1'b0, hi_f, lo_f}, 33'd123);
    end

    // R11: accumulation through the result register
    @(negedge clk);
    pass_ab = 1'b1; pass_f = 1'b0; fn = 3'd0; f_load_n = 1'b0;
    tick();
    sel = 2'd0; fn = 3'd3; cin_sys = 1'b0; a32 = 32'd37;
    for (int k = 1; k <= 10; k++) begin
      tick(); #1;
      chk("R11 accumulate", {1'b0, hi_f, lo_f}, 33'(37 * k));
    end
    f_load_n = 1'b1; pass_f = 1'b1;
    #1;
    chk("R11 feedback from register when transparent", {1'b0, hi_f, lo_f}, 33'd407);
    @(negedge clk);

    // R4 R5 R6 R7 R8 R9 R12: sweep
    for (int md = 0; md < 4; md++)
      for (int sl = 0; sl < 4; sl++)
        for (int f = 0; f < 8; f++)
          for (int ci = 0; ci < 2; ci++)
            for (int p = 0; p < 6; p++) begin
              logic [63:0] pr;
              pr = pattern(p);
              apply(md[1:0], sl[1:0], f[2:0], ci[0], pr[63:32], pr[31:0],
                    {pr[15:0], pr[63:48]});
            end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule